// File: doc/BRIEF.md
# Exception Escalation Controller

This block sits between the fault sources of a processor core and its interrupt delivery stage. A fault source raises a request carrying a vector number and an error code. The controller counts how deeply exceptions are nested. On the second level of nesting it substitutes the double-fault vector. On the third level it gives up and pulses a processor reset instead of delivering anything.

For every request it delivers, the controller rewinds the core: it pulses a load of the saved instruction pointer and a clear of the instruction prefix state. It then issues one read of the vector table entry. In protected mode the entry is an 8-byte gate descriptor. In real mode it is a 4-byte offset/selector pair, which the controller turns into an equivalent 16-bit interrupt gate. The decoded gate is held for the delivery stage until that stage reports completion. A successful completion returns the nesting depth to zero. A failed completion leaves the depth in place, so the fault raised by the failure escalates.

Top module: `exc_escalate`

## Requirements
- R1: After reset, every output is low and the nesting depth is zero, so the first request is delivered under its own vector.
- R2: Each accepted request raises the nesting depth by one. When the new depth is two or more, the vector used for the read and shown on gate_vector is 8 (double fault) instead of the requested one.
- R3: A request that would bring the depth to three issues no read and no gate. Instead cpu_reset pulses high for one cycle, starting the cycle after the request, and the depth returns to zero.
- R4: Every request that is not turned into a reset pulses ip_load and prefix_clear for one cycle, in the same cycle as mem_rd_req. During that cycle ip_value equals saved_ip as sampled with the request.
- R5: In protected mode (pe_mode=1 when the request is taken), the read is 8 bytes (mem_rd_wide=1) at tbl_base + vector*8. The entry fields are: offset = {data[63:48], data[15:0]}, selector = data[31:16], type = data[43:40], privilege = data[46:45] and present = data[47].
- R6: In real mode, the read is 4 bytes (mem_rd_wide=0) at tbl_base + vector*4. The gate then has offset = {16'h0, data[15:0]}, selector = data[31:16], type 4'h6, privilege 0 and present 1.
- R7: gate_push_err is 1 only when the request was taken in protected mode and the delivered vector is one of 8, 10, 11, 12, 13, 14 or 17. gate_err_code carries the error code of the request that started the read.
- R8: gate_valid rises the cycle after mem_rd_valid and stays high, with stable fields, until dlv_done. If dlv_ok is 1 with dlv_done, the depth returns to zero. If dlv_ok is 0, the depth is kept.
- R9: A request that arrives while a read is outstanding or a gate is pending counts as nested. The abandoned read's data is ignored, and a request wins over read data that arrives in the same cycle.
- R10: When dlv_done with dlv_ok and a new request fall in the same cycle, the depth is cleared first. The request is then taken at depth one and keeps its own vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request strobe |
| req_vector | input | 8 | Requested vector number |
| req_err_code | input | 32 | Error code that goes with the request |
| pe_mode | input | 1 | Protection enabled (1) or real mode (0) |
| tbl_base | input | 32 | Base address of the vector table |
| saved_ip | input | 32 | Instruction pointer saved at the start of the faulting instruction |
| mem_rd_req | output | 1 | One-cycle read request for the table entry |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_wide | output | 1 | 1: 8-byte read, 0: 4-byte read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Read data, little-endian |
| ip_load | output | 1 | Load ip_value into the current instruction pointer |
| ip_value | output | 32 | Restored instruction pointer |
| prefix_clear | output | 1 | Clear all instruction prefix flags |
| cpu_reset | output | 1 | Processor reset pulse on triple fault |
| gate_valid | output | 1 | Gate descriptor valid for the delivery stage |
| gate_vector | output | 8 | Vector actually delivered |
| gate_offset | output | 32 | Handler offset |
| gate_selector | output | 16 | Handler code selector |
| gate_type | output | 4 | Gate type |
| gate_dpl | output | 2 | Gate privilege level |
| gate_present | output | 1 | Gate present |
| gate_push_err | output | 1 | Delivery stage must push the error code |
| gate_err_code | output | 32 | Error code to push |
| dlv_done | input | 1 | Delivery stage finished with the gate |
| dlv_ok | input | 1 | Delivery succeeded (valid with dlv_done) |

## Verification
Two pairs of events can fall in one cycle. The first is a new request and the return of table read data. The bench drives both on the same edge and expects no gate, plus a fresh read at the double-fault entry address. The second is a successful completion and a new request. Here the bench expects the new read to use the requested vector, which shows that the clear came before the increment.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_DELIVER = 2'd2
    } esc_state_e;

    // gate type used for a real-mode vector (16-bit interrupt gate)
    localparam logic [3:0] GATE_INT16 = 4'h6;

endpackage

// File: rtl/exc_err_class.sv
module exc_err_class #(
    parameter int          VEC_W    = 8,
    parameter logic [31:0] ERR_MASK = 32'h0002_7D00
) (
    input  logic [VEC_W-1:0] vec_i,
    output logic             has_err_o
);
    localparam int LOW_W = (VEC_W < 5) ? VEC_W : 5;

    logic in_range;

    generate
        if (VEC_W > 5) begin : g_wide
            assign in_range = (vec_i[VEC_W-1:5] == '0);
        end else begin : g_narrow
            assign in_range = 1'b1;
        end
    endgenerate

    assign has_err_o = in_range && ERR_MASK[vec_i[LOW_W-1:0]];

endmodule

// File: rtl/exc_entry_addr.sv
module exc_entry_addr #(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic              wide_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int SH_NARROW = 2;
    localparam int SH_WIDE   = 3;

    logic [ADDR_W-1:0] vec_ext;

    assign vec_ext = ADDR_W'(vec_i);
    assign addr_o  = base_i + (wide_i ? (vec_ext << SH_WIDE) : (vec_ext << SH_NARROW));

endmodule

// File: rtl/exc_gate_decode.sv
module exc_gate_decode
    import exc_esc_pkg::*;
(
    input  logic [63:0] data_i,
    input  logic        prot_i,
    output logic [31:0] offset_o,
    output logic [15:0] sel_o,
    output logic [3:0]  type_o,
    output logic [1:0]  dpl_o,
    output logic        present_o
);
    logic unused_param_byte;
    assign unused_param_byte = ^{data_i[39:32], data_i[44]};

    always_comb begin
        sel_o = data_i[31:16];
        if (prot_i) begin
            offset_o  = {data_i[63:48], data_i[15:0]};
            type_o    = data_i[43:40];
            dpl_o     = data_i[46:45];
            present_o = data_i[47];
        end else begin
            offset_o  = {16'h0000, data_i[15:0]};
            type_o    = GATE_INT16;
            dpl_o     = 2'd0;
            present_o = 1'b1;
        end
    end

endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
    import exc_esc_pkg::*;
#(
    parameter int          VEC_W      = 8,
    parameter int          ADDR_W     = 32,
    parameter int          ERR_W      = 32,
    parameter int          NEST_LIMIT = 3,
    parameter int          DF_VECTOR  = 8,
    parameter logic [31:0] ERR_MASK   = 32'h0002_7D00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic [ERR_W-1:0]  req_err_code,
    input  logic              pe_mode,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [31:0]       saved_ip,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              mem_rd_wide,
    input  logic              mem_rd_valid,
    input  logic [63:0]       mem_rd_data,
    output logic              ip_load,
    output logic [31:0]       ip_value,
    output logic              prefix_clear,
    output logic              cpu_reset,
    output logic              gate_valid,
    output logic [VEC_W-1:0]  gate_vector,
    output logic [31:0]       gate_offset,
    output logic [15:0]       gate_selector,
    output logic [3:0]        gate_type,
    output logic [1:0]        gate_dpl,
    output logic              gate_present,
    output logic              gate_push_err,
    output logic [ERR_W-1:0]  gate_err_code,
    input  logic              dlv_done,
    input  logic              dlv_ok
);
    localparam int CNT_W = $clog2(NEST_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(NEST_LIMIT);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [VEC_W-1:0] VEC_DF    = VEC_W'(DF_VECTOR);

    typedef struct packed {
        esc_state_e        state;
        logic [CNT_W-1:0]  nest;
        logic [VEC_W-1:0]  vec;
        logic [ERR_W-1:0]  err;
        logic              pe;
        logic [31:0]       ip;
        logic              rd_req;
        logic [ADDR_W-1:0] rd_addr;
        logic              rd_wide;
        logic              ip_load;
        logic              pfx_clr;
        logic              rst_pulse;
        logic              g_valid;
        logic [31:0]       g_offset;
        logic [15:0]       g_sel;
        logic [3:0]        g_type;
        logic [1:0]        g_dpl;
        logic              g_present;
        logic              g_push_err;
    } esc_regs_t;

    esc_regs_t st_d, st_q;

    // combinational helpers
    logic [VEC_W-1:0]  vec_sel;
    logic [CNT_W-1:0]  nest_base;
    logic [CNT_W-1:0]  nest_inc;
    logic [ADDR_W-1:0] entry_addr;
    logic              vec_has_err;
    logic [31:0]       dec_offset;
    logic [15:0]       dec_sel;
    logic [3:0]        dec_type;
    logic [1:0]        dec_dpl;
    logic              dec_present;

    // depth seen by a request in this cycle: a successful completion clears first
    always_comb begin
        nest_base = st_q.nest;
        if (st_q.state == ST_DELIVER && dlv_done && dlv_ok) begin
            nest_base = '0;
        end
        nest_inc = nest_base + CNT_ONE;
        vec_sel  = (nest_inc > CNT_ONE) ? VEC_DF : req_vector;
    end

    exc_entry_addr #(
        .VEC_W  (VEC_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .base_i (tbl_base),
        .vec_i  (vec_sel),
        .wide_i (pe_mode),
        .addr_o (entry_addr)
    );

    exc_err_class #(
        .VEC_W    (VEC_W),
        .ERR_MASK (ERR_MASK)
    ) u_class (
        .vec_i     (st_q.vec),
        .has_err_o (vec_has_err)
    );

    exc_gate_decode u_decode (
        .data_i    (mem_rd_data),
        .prot_i    (st_q.pe),
        .offset_o  (dec_offset),
        .sel_o     (dec_sel),
        .type_o    (dec_type),
        .dpl_o     (dec_dpl),
        .present_o (dec_present)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rd_req    = 1'b0;
        st_d.ip_load   = 1'b0;
        st_d.pfx_clr   = 1'b0;
        st_d.rst_pulse = 1'b0;

        case (st_q.state)
            ST_FETCH: begin
                if (mem_rd_valid && !req_valid) begin
                    st_d.state      = ST_DELIVER;
                    st_d.g_valid    = 1'b1;
                    st_d.g_offset   = dec_offset;
                    st_d.g_sel      = dec_sel;
                    st_d.g_type     = dec_type;
                    st_d.g_dpl      = dec_dpl;
                    st_d.g_present  = dec_present;
                    st_d.g_push_err = st_q.pe && vec_has_err;
                end
            end
            ST_DELIVER: begin
                if (dlv_done) begin
                    st_d.state      = ST_IDLE;
                    st_d.g_valid    = 1'b0;
                    st_d.g_push_err = 1'b0;
                    st_d.nest       = nest_base;
                end
            end
            default: ;
        endcase

        if (req_valid) begin
            st_d.g_valid    = 1'b0;
            st_d.g_push_err = 1'b0;
            if (nest_inc >= CNT_LIMIT) begin
                st_d.state     = ST_IDLE;
                st_d.nest      = '0;
                st_d.rst_pulse = 1'b1;
            end else begin
                st_d.state   = ST_FETCH;
                st_d.nest    = nest_inc;
                st_d.vec     = vec_sel;
                st_d.err     = req_err_code;
                st_d.pe      = pe_mode;
                st_d.ip      = saved_ip;
                st_d.rd_req  = 1'b1;
                st_d.rd_addr = entry_addr;
                st_d.rd_wide = pe_mode;
                st_d.ip_load = 1'b1;
                st_d.pfx_clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_rd_req    = st_q.rd_req;
    assign mem_rd_addr   = st_q.rd_addr;
    assign mem_rd_wide   = st_q.rd_wide;
    assign ip_load       = st_q.ip_load;
    assign ip_value      = st_q.ip;
    assign prefix_clear  = st_q.pfx_clr;
    assign cpu_reset     = st_q.rst_pulse;
    assign gate_valid    = st_q.g_valid;
    assign gate_vector   = st_q.vec;
    assign gate_offset   = st_q.g_offset;
    assign gate_selector = st_q.g_sel;
    assign gate_type     = st_q.g_type;
    assign gate_dpl      = st_q.g_dpl;
    assign gate_present  = st_q.g_present;
    assign gate_push_err = st_q.g_push_err;
    assign gate_err_code = st_q.err;

    // R3: a triple fault produces neither a read nor a gate
    a_r3_reset_alone: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset |-> (!mem_rd_req && !gate_valid && !ip_load));

    // R2: nested reads always target the double-fault entry
    a_r2_double_fault_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && st_q.nest > CNT_ONE) |-> (gate_vector == VEC_DF));

    // R4: rewind pulses come with the read and carry the sampled pointer
    a_r4_rewind_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |-> (mem_rd_req && prefix_clear && ip_value == $past(saved_ip)));

    // R7: an error code is pushed only for a gate taken in protected mode
    a_r7_err_needs_pe: assert property (@(posedge clk) disable iff (!rst_n)
        gate_push_err |-> (gate_valid && st_q.pe));

    // R8: gate held stable until completion
    a_r8_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_valid && !dlv_done && !req_valid) |=>
            (gate_valid && $stable(gate_offset) && $stable(gate_selector)));

    // R8: successful completion clears the nesting depth
    a_r8_clear_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_valid && dlv_done && dlv_ok && !req_valid) |=> (st_q.nest == '0));

endmodule

// File: tb/test_exc_escalate.sv
module test_exc_escalate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic [31:0] req_err_code = '0;
    logic        pe_mode = 1'b0;
    logic [31:0] tbl_base = '0;
    logic [31:0] saved_ip = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_wide;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        ip_load;
    logic [31:0] ip_value;
    logic        prefix_clear;
    logic        cpu_reset;
    logic        gate_valid;
    logic [7:0]  gate_vector;
    logic [31:0] gate_offset;
    logic [15:0] gate_selector;
    logic [3:0]  gate_type;
    logic [1:0]  gate_dpl;
    logic        gate_present;
    logic        gate_push_err;
    logic [31:0] gate_err_code;
    logic        dlv_done = 1'b0;
    logic        dlv_ok = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    exc_escalate i_exc_escalate (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_vector (req_vector), .req_err_code (req_err_code),
        .pe_mode (pe_mode), .tbl_base (tbl_base), .saved_ip (saved_ip),
        .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr), .mem_rd_wide (mem_rd_wide),
        .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
        .ip_load (ip_load), .ip_value (ip_value), .prefix_clear (prefix_clear),
        .cpu_reset (cpu_reset), .gate_valid (gate_valid), .gate_vector (gate_vector),
        .gate_offset (gate_offset), .gate_selector (gate_selector), .gate_type (gate_type),
        .gate_dpl (gate_dpl), .gate_present (gate_present), .gate_push_err (gate_push_err),
        .gate_err_code (gate_err_code), .dlv_done (dlv_done), .dlv_ok (dlv_ok)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic raise(input logic [7:0] v, input logic [31:0] e);
        req_valid = 1'b1; req_vector = v; req_err_code = e;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic respond(input logic [63:0] d);
        mem_rd_valid = 1'b1; mem_rd_data = d;
        @(negedge clk);
        mem_rd_valid = 1'b0;
    endtask

    task automatic finish_dlv(input logic ok);
        dlv_done = 1'b1; dlv_ok = ok;
        @(negedge clk);
        dlv_done = 1'b0; dlv_ok = 1'b0;
    endtask

    task automatic t_reset_state;
        check("R1 mem_rd_req", mem_rd_req, 0);
        check("R1 gate_valid", gate_valid, 0);
        check("R1 cpu_reset", cpu_reset, 0);
        check("R1 ip_load", ip_load, 0);
        check("R1 prefix_clear", prefix_clear, 0);
    endtask

    task automatic t_real_mode;
        pe_mode = 1'b0; tbl_base = 32'h0000_0400; saved_ip = 32'h1111_2222;
        raise(8'h21, 32'h0);
        check("R4 ip_load", ip_load, 1);
        check("R4 prefix_clear", prefix_clear, 1);
        check("R4 ip_value", ip_value, 32'h1111_2222);
        check("R6 rd_req", mem_rd_req, 1);
        check("R6 rd_addr", mem_rd_addr, 32'h0000_0484);
        check("R6 rd_wide", mem_rd_wide, 0);
        check("R1 first vector kept", gate_vector, 8'h21);
        @(negedge clk);
        check("R4 ip_load one cycle", ip_load, 0);
        check("R8 no gate before data", gate_valid, 0);
        respond(64'hAAAA_BBBB_F000_1234);
        check("R8 gate_valid", gate_valid, 1);
        check("R6 offset", gate_offset, 32'h0000_1234);
        check("R6 selector", gate_selector, 16'hF000);
        check("R6 type", gate_type, 4'h6);
        check("R6 dpl", gate_dpl, 0);
        check("R6 present", gate_present, 1);
        check("R7 real no push", gate_push_err, 0);
        @(negedge clk);
        check("R8 gate held", gate_valid, 1);
        check("R8 offset held", gate_offset, 32'h0000_1234);
        finish_dlv(1'b1);
        check("R8 gate dropped", gate_valid, 0);
    endtask

    task automatic t_real_err_vector;
        raise(8'd13, 32'h55);
        check("R6 addr vec13", mem_rd_addr, 32'h0000_0434);
        respond(64'h0000_0000_0070_0100);
        check("R7 real vec13 no push", gate_push_err, 0);
        finish_dlv(1'b1);
    endtask

    task automatic t_prot_page_fault;
        pe_mode = 1'b1; tbl_base = 32'h0010_0000; saved_ip = 32'hCAFE_0010;
        raise(8'd14, 32'h1234_0004);
        check("R5 rd_addr", mem_rd_addr, 32'h0010_0070);
        check("R5 rd_wide", mem_rd_wide, 1);
        check("R4 ip_value pe", ip_value, 32'hCAFE_0010);
        respond(64'hC0DE_EE00_0010_5678);
        check("R5 offset", gate_offset, 32'hC0DE_5678);
        check("R5 selector", gate_selector, 16'h0010);
        check("R5 type", gate_type, 4'hE);
        check("R5 dpl", gate_dpl, 2'd3);
        check("R5 present", gate_present, 1);
        check("R7 push vec14", gate_push_err, 1);
        check("R7 err code", gate_err_code, 32'h1234_0004);
        finish_dlv(1'b1);
    endtask

    task automatic t_prot_no_err;
        raise(8'd3, 32'h9);
        check("R5 addr vec3", mem_rd_addr, 32'h0010_0018);
        respond(64'h0000_0E00_0008_0000);
        check("R5 present zero", gate_present, 0);
        check("R7 vec3 no push", gate_push_err, 0);
        finish_dlv(1'b1);
    endtask

    task automatic t_nested;
        raise(8'd13, 32'h1);
        raise(8'd6, 32'h2);
        check("R9 nested reads again", mem_rd_req, 1);
        check("R2 df addr", mem_rd_addr, 32'h0010_0040);
        check("R2 df vector", gate_vector, 8'd8);
        respond(64'h0000_8E00_0008_2000);
        check("R7 df pushes", gate_push_err, 1);
        finish_dlv(1'b1);
        raise(8'd5, 32'h0);
        check("R8 cleared after ok", mem_rd_addr, 32'h0010_0028);
        respond(64'h0);
        finish_dlv(1'b1);
    endtask

    task automatic t_triple;
        raise(8'd13, 32'h0);
        respond(64'h0);
        finish_dlv(1'b0);
        raise(8'd11, 32'h0);
        check("R8 fail keeps depth", mem_rd_addr, 32'h0010_0040);
        respond(64'h0);
        finish_dlv(1'b0);
        raise(8'd2, 32'h0);
        check("R3 cpu_reset", cpu_reset, 1);
        check("R3 no read", mem_rd_req, 0);
        check("R3 no gate", gate_valid, 0);
        check("R3 no ip_load", ip_load, 0);
        @(negedge clk);
        check("R3 reset one cycle", cpu_reset, 0);
        raise(8'd4, 32'h0);
        check("R3 depth back to zero", mem_rd_addr, 32'h0010_0020);
        respond(64'h0);
        finish_dlv(1'b1);
    endtask

    task automatic t_collide;
        raise(8'd10, 32'h0);
        req_valid = 1'b1; req_vector = 8'd6; mem_rd_valid = 1'b1;
        mem_rd_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        req_valid = 1'b0; mem_rd_valid = 1'b0;
        check("R9 data dropped", gate_valid, 0);
        check("R9 new read", mem_rd_req, 1);
        check("R9 df addr", mem_rd_addr, 32'h0010_0040);
        respond(64'h0000_8F00_0008_0042);
        check("R9 new data used", gate_offset, 32'h0000_0042);
        finish_dlv(1'b1);
    endtask

    task automatic t_done_with_req;
        raise(8'd7, 32'h0);
        respond(64'h0);
        dlv_done = 1'b1; dlv_ok = 1'b1; req_valid = 1'b1; req_vector = 8'd9;
        @(negedge clk);
        dlv_done = 1'b0; dlv_ok = 1'b0; req_valid = 1'b0;
        check("R10 own vector", mem_rd_addr, 32'h0010_0048);
        check("R10 vector out", gate_vector, 8'd9);
        respond(64'h0);
        finish_dlv(1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state;
        t_real_mode;
        t_real_err_vector;
        t_prot_page_fault;
        t_prot_no_err;
        t_nested;
        t_triple;
        t_collide;
        t_done_with_req;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule